// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns the peripheral clock into a 16x-oversampling tick enable for a serial transmitter and receiver. The tick period is set by a 16-bit integer divisor, given as a high byte and a low byte. A fractional prescaler, set by a 4-bit add value and a 4-bit multiplier value, stretches some periods. The average tick rate equals clock / (divisor * (1 + add/mul)), and the bit rate is one sixteenth of that. When the add value is zero the prescaler is bypassed and the divider is purely integer.

The fraction is carried in an accumulator. At the end of every base period it adds the add value. When the sum reaches the multiplier value, it subtracts the multiplier and inserts one extra divisor period before the tick. The block checks the setting for legality, and an illegal setting stops the ticks and raises a configuration-error flag. Any change to a divisor or prescaler input restarts the counter and clears the accumulator.

A three-state machine sequences the counter:
- `ST_IDLE`: stopped.
- `ST_BASE`: counting a base divisor period.
- `ST_STRETCH`: counting an inserted extra period.

Its transitions are:
- IDLE->BASE: on the first cycle with run permission.
- BASE->BASE: at a period end that fires a tick.
- BASE->STRETCH: at a period end where the accumulator reaches the multiplier.
- STRETCH->BASE: at the end of the extra period, which fires the tick.
- any->IDLE: when enable is low, the setting is illegal, or an input changed.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `tick_16x` and `cfg_err` are 0.
- R2: `cfg_err` is registered and, one cycle after the inputs, equals 1 exactly when any of these holds:
  - the divisor D = 256*`div_hi` + `div_lo` is 0;
  - `frac_mul` is 0;
  - `frac_add` > 14;
  - `frac_add` >= `frac_mul`;
  - `frac_add` > 0 and `div_hi` is 0 and `div_lo` < 2.
  The flag does not depend on `en`.
- R3: No tick occurs while `cfg_err` is 1, or in the cycle after `en` is sampled 0.
- R4: With `frac_add` = 0, consecutive ticks are exactly D cycles apart.
- R5: With `frac_add` > 0, an accumulator starts at 0 and gains `frac_add` at each tick interval. If the sum reaches `frac_mul`, it loses `frac_mul` and that interval lasts 2D cycles; otherwise the interval lasts D cycles.
- R6: Any `frac_mul` consecutive tick intervals total D*(`frac_mul` + `frac_add`) cycles.
- R7: With D >= 2, the tick is high for a single cycle.
- R8: With a stable legal setting, the first tick is high in the cycle after the (D+1)th rising edge, counting the edge that first samples `en` = 1 as the first.
- R9: A change to `div_hi`, `div_lo`, `frac_add` or `frac_mul` while enabled restarts the count. The first tick comes after the (D+2)th edge, counting the edge that samples the change as the first, and the intervals that follow start again from an accumulator of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| frac_add | input | 4 | Fractional add value |
| frac_mul | input | 4 | Fractional multiplier value |
| tick_16x | output | 1 | One-cycle 16x oversampling tick |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the block with its default 8-bit divisor bytes and 4-bit prescaler fields, so every legal multiplier from 1 to 15 and every add value is reachable. Random settings mostly keep the high byte at zero, which keeps periods short enough to observe many full accumulator cycles within the run. Directed settings with a non-zero high byte reach the 256-and-above divisor range, and the low-byte minimum rule is probed on both sides of the high byte being zero.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BASE    = 2'd1,
        ST_STRETCH = 2'd2
    } fb_state_e;

    function automatic logic fb_setting_ok(
        input logic [15:0] dvsr,
        input logic        hi_zero,
        input logic [15:0] lo_val,
        input logic [7:0]  add_v,
        input logic [7:0]  mul_v,
        input logic [7:0]  mul_max
    );
        logic ok;
        ok = 1'b1;
        if (dvsr == 16'd0)                                   ok = 1'b0;
        if (mul_v == 8'd0 || mul_v > mul_max)                ok = 1'b0;
        if (add_v > (mul_max - 8'd1))                        ok = 1'b0;
        if (add_v >= mul_v)                                  ok = 1'b0;
        if (add_v != 8'd0 && hi_zero && lo_val < 16'd2)      ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic [DIV_W-1:0]  dvsr,
    output logic              legal,
    output logic              chg,
    output logic              err_q
);
    import frac_baud_pkg::*;

    localparam int CFG_W = DIV_W + 2 * FRAC_W;
    localparam logic [7:0] MUL_MAX = 8'((1 << FRAC_W) - 1);

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_prev;

    assign dvsr    = {div_hi, div_lo};
    assign cfg_now = {div_hi, div_lo, frac_add, frac_mul};
    assign legal   = fb_setting_ok(16'(dvsr), (div_hi == '0), 16'(div_lo),
                                   8'(frac_add), 8'(frac_mul), MUL_MAX);
    assign chg     = (cfg_now != cfg_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_prev <= '0;
            err_q    <= 1'b0;
        end else begin
            cfg_prev <= cfg_now;
            err_q    <= ~legal;
        end
    end

    // R2: flag follows legality of the previous cycle's setting
    p_err_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_mul == '0) |=> err_q);

endmodule

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic              stretch_req,
    output logic [FRAC_W-1:0] acc_val
);
    logic [FRAC_W:0] sum;

    assign sum         = {1'b0, acc_val} + {1'b0, frac_add};
    assign stretch_req = (sum >= {1'b0, frac_mul});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_val <= '0;
        end else if (clr) begin
            acc_val <= '0;
        end else if (step) begin
            if (stretch_req) acc_val <= FRAC_W'(sum - {1'b0, frac_mul});
            else             acc_val <= sum[FRAC_W-1:0];
        end
    end

    // R9: a clear leaves the accumulator empty
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_val == '0));

endmodule

// File: rtl/frac_baud_ctrl.sv
module frac_baud_ctrl #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] dvsr,
    input  logic             stretch_req,
    output logic             step,
    output logic             busy,
    output logic             tick_q
);
    import frac_baud_pkg::*;

    fb_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             period_end;
    logic             fire;

    assign period_end = go && (cnt_q == '0);
    assign busy       = (state_q != ST_IDLE);
    assign step       = period_end && (state_q == ST_BASE);

    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_BASE;
                ST_BASE:    if (period_end && stretch_req) state_d = ST_STRETCH;
                ST_STRETCH: if (period_end) state_d = ST_BASE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_IDLE:    fire = 1'b0;
            ST_BASE:    fire = period_end && !stretch_req;
            ST_STRETCH: fire = period_end;
            default:    fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= fire;
            if (!go || state_q == ST_IDLE || cnt_q == '0) cnt_q <= dvsr - 1'b1;
            else                                           cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: the end of an inserted period always produces the tick
    p_stretch_ends_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH && period_end) |=> tick_q);

    // R4: counter never exceeds the divisor while the setting is steady
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |-> (cnt_q < dvsr));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic              tick_16x,
    output logic              cfg_err
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0]  dvsr;
    logic              legal, chg, go;
    logic              step, busy, stretch_req;
    logic [FRAC_W-1:0] acc_val;

    frac_baud_cfg #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .div_hi(div_hi), .div_lo(div_lo),
        .frac_add(frac_add), .frac_mul(frac_mul),
        .dvsr(dvsr), .legal(legal), .chg(chg), .err_q(cfg_err)
    );

    assign go = en && legal && !chg;

    frac_baud_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(!busy), .step(step),
        .frac_add(frac_add), .frac_mul(frac_mul),
        .stretch_req(stretch_req), .acc_val(acc_val)
    );

    frac_baud_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .dvsr(dvsr),
        .stretch_req(stretch_req), .step(step), .busy(busy), .tick_q(tick_16x)
    );

    // R3: an illegal setting never coexists with a tick
    p_no_tick_on_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tick_16x);

    // R3: disabling stops ticks at the next cycle
    p_off_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick_16x);

    // R7: a tick lasts one cycle when the divisor is two or more
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_16x && dvsr >= 2) |=> !tick_16x);

    // R5: accumulator stays below the multiplier while running steadily
    p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |-> (acc_val < frac_mul));

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div_hi = 8'd0, div_lo = 8'd4;
    logic [3:0] frac_add = 4'd0, frac_mul = 4'd1;
    logic       tick_16x, cfg_err;

    int  cyc = 0;
    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .div_hi(div_hi), .div_lo(div_lo),
        .frac_add(frac_add), .frac_mul(frac_mul),
        .tick_16x(tick_16x), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit legal_f(int hi, int lo, int ad, int mu);
        int d;
        d = hi * 256 + lo;
        if (d == 0 || mu == 0 || ad > 14 || ad >= mu) return 1'b0;
        if (ad > 0 && hi == 0 && lo < 2) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int t, output bit ok);
        ok = 1'b0;
        t  = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (tick_16x) begin
                ok = 1'b1;
                t  = cyc;
                break;
            end
        end
    endtask

    task automatic set_cfg(int hi, int lo, int ad, int mu);
        div_hi = 8'(hi); div_lo = 8'(lo); frac_add = 4'(ad); frac_mul = 4'(mu);
    endtask

    // measure ticks after start and compare against the interval model
    task automatic measure(int d, int ad, int mu, int t0, int lat_exp, string lat_req);
        int acc, t_prev, t_now, sum_iv, lat;
        int len[0:31];
        int n;
        bit ok;
        n = 2 * mu + 2;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            acc += ad;
            if (acc >= mu) begin acc -= mu; len[i] = 2 * d; end
            else len[i] = d;
        end
        wait_tick(t_prev, ok);
        lat = t_prev - t0;
        check(ok && lat == lat_exp, lat_req, lat, lat_exp);
        if (!ok) return;
        if (d >= 2) begin
            @(negedge clk);
            check(!tick_16x, "R7", int'(tick_16x), 0);
        end
        sum_iv = 0;
        for (int i = 1; i < n; i++) begin
            wait_tick(t_now, ok);
            check(ok && (t_now - t_prev) == len[i], (ad == 0) ? "R4" : "R5",
                  t_now - t_prev, len[i]);
            if (!ok) return;
            if (i >= 2 && i <= mu + 1) sum_iv += t_now - t_prev;
            t_prev = t_now;
        end
        check(sum_iv == d * (mu + ad), "R6", sum_iv, d * (mu + ad));
        check(cfg_err == 1'b0, "R2", int'(cfg_err), 0);
    endtask

    task automatic run_legal(int hi, int lo, int ad, int mu);
        int t0;
        @(negedge clk);
        en = 1'b0;
        set_cfg(hi, lo, ad, mu);
        repeat (3) @(negedge clk);
        en = 1'b1;
        t0 = cyc;
        measure(hi * 256 + lo, ad, mu, t0, hi * 256 + lo + 1, "R8");
    endtask

    task automatic run_illegal(int hi, int lo, int ad, int mu);
        int seen;
        @(negedge clk);
        en = 1'b1;
        set_cfg(hi, lo, ad, mu);
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R2", int'(cfg_err), 1);
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (tick_16x) seen++;
        end
        check(seen == 0, "R3", seen, 0);
    endtask

    initial begin : wd
        wait (cyc >= WD_LIMIT);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seen, t0, hi, lo, ad, mu;
        void'($urandom(32'd20171216));
        repeat (3) @(negedge clk);
        check(tick_16x == 1'b0, "R1", int'(tick_16x), 0);
        check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
        rst_n = 1'b1;

        // R3: disabled with a legal setting gives no ticks
        set_cfg(0, 3, 0, 1);
        seen = 0;
        repeat (40) begin @(negedge clk); if (tick_16x) seen++; end
        check(seen == 0, "R3", seen, 0);

        // R4/R8 directed integer cases, including divisor 1 and above 255
        run_legal(0, 1, 0, 1);
        run_legal(0, 5, 0, 7);
        run_legal(1, 0, 0, 1);
        // R5 directed fractional cases
        run_legal(0, 2, 1, 2);
        run_legal(0, 3, 14, 15);
        run_legal(1, 1, 1, 2);
        run_legal(1, 0, 3, 5);

        // R2 directed illegal cases
        run_illegal(0, 0, 0, 1);
        run_illegal(0, 4, 0, 0);
        run_illegal(0, 4, 15, 15);
        run_illegal(0, 9, 5, 5);
        run_illegal(0, 1, 1, 2);
        // R2: low byte under 2 is legal when the high byte is non-zero
        run_legal(1, 1, 1, 3);

        // R2: flag is independent of enable
        @(negedge clk);
        en = 1'b0;
        set_cfg(0, 6, 7, 3);
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R2", int'(cfg_err), 1);

        // R9: change mid-count restarts counter and accumulator
        @(negedge clk);
        set_cfg(0, 40, 0, 1);
        en = 1'b1;
        repeat (17) @(negedge clk);
        set_cfg(0, 7, 3, 5);
        t0 = cyc;
        measure(7, 3, 5, t0, 9, "R9");
        repeat (4) @(negedge clk);
        set_cfg(0, 4, 2, 3);
        t0 = cyc;
        measure(4, 2, 3, t0, 6, "R9");

        // random settings
        for (int k = 0; k < 40; k++) begin
            hi = (($urandom % 8) == 0) ? 1 : 0;
            lo = (hi != 0) ? int'($urandom % 4) : int'($urandom % 24);
            ad = int'($urandom % 16);
            mu = int'($urandom % 16);
            if (($urandom % 3) == 0) ad = 0;
            if (legal_f(hi, lo, ad, mu)) run_legal(hi, lo, ad, mu);
            else                         run_illegal(hi, lo, ad, mu);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule